// File: doc/BRIEF.md
# Multiplier-Based Word Shifter and Rotator

This block shifts or rotates a 32-bit data word by a dynamic amount. It does not use a mux tree. It multiplies the word by a power of two, 2^N, and forms a 64-bit product. The result is taken from that product: the lower half gives a left shift, the upper half gives a right shift, and the two halves ORed together give a rotation. Setting the top multiplicand bit from the data sign makes the upper half fill with copies of the sign bit, which gives an arithmetic right shift.

The operation is chosen again on every clock cycle from three controls: a direction bit, a rotate bit and a sign bit. The power-of-two operand can come from two places. It can be driven directly on a 32-bit port, or it can be built inside the block from a 5-bit count by a one-hot decoder. A select input picks between the two. The result is registered, so an output appears one cycle after its inputs.

Top module: `mulshift_rot`

## Requirements
- R1: An active-low asynchronous reset clears the result output to 0x00000000.
- R2: The output changes only at a rising clock edge. It shows the result of the inputs present at that edge, so the latency is one cycle.
- R3: With rot_en=0 and dir_right=0, the result is the low 32 bits of din×2^N, which is din shifted left by N with zero fill. sign_en has no effect in this case.
- R4: With rot_en=0, dir_right=1 and sign_en=0, the result is the high 32 bits of the unsigned product, which is din shifted right logically by 32−N. For N=0 the result is 0.
- R5: With rot_en=0, dir_right=1 and sign_en=1, din is treated as signed. The result is din shifted right arithmetically by 32−N, with the vacated bits filled from din[31]. For N=0 every bit equals din[31].
- R6: With rot_en=1, the result is din rotated left by N, formed as the OR of the high and low product halves. din is always treated as unsigned here, so sign_en has no effect. For N=0 the result is din.
- R7: When rot_en=1 and dir_right=1 together, the block performs a rotation.
- R8: With cnt_sel=1, the operand is 1<<cnt_in and pow_in is ignored. With cnt_sel=0, the operand is pow_in and cnt_in is ignored. pow_in should hold a single set bit at position N.
- R9: A different operation, operand and word may be applied on every cycle. Each result depends only on its own inputs.
- R10: For din=0xAABBCCDD and operand 0x100, the results are:
  - left shift: 0xBBCCDD00
  - logical right shift: 0x000000AA
  - arithmetic right shift: 0xFFFFFFAA
  - rotation: 0xBBCCDDAA

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 32 | Word to shift or rotate |
| pow_in | input | 32 | Direct power-of-two operand 2^N |
| cnt_in | input | 5 | Binary shift count N, used when cnt_sel=1 |
| cnt_sel | input | 1 | 1: decode cnt_in; 0: use pow_in |
| dir_right | input | 1 | 1 selects a right shift when rot_en=0 |
| rot_en | input | 1 | 1 selects rotation, which overrides dir_right |
| sign_en | input | 1 | 1 treats din as signed for right shifts |
| dout | output | 32 | Registered result |

## Verification
The bench concentrates on a count of zero, where each operation has its own answer:
- A right shift must give all zeros, or all sign bits when arithmetic. A design that took the upper half without sign-extending the multiplicand would return zeros instead of 0xFFFFFFFF.
- A rotation must return the word unchanged. A rotation that sign-extended would smear ones across the upper half of negative words.

The bench also checks:
- A count of 31 and the top bit of the operand port, which catch an off-by-one in the decoder or in the product slice.
- Both-controls-high, which catches a priority that favours the shift.
- A garbage value on the unused operand source, which catches the wrong source being selected.
- Back-to-back vector changes, which show whether a result has been held a cycle too long or leaked early.

// File: rtl/shf_pkg.sv
package shf_pkg;
    typedef enum logic [1:0] {
        SHF_LEFT  = 2'd0,
        SHF_RIGHT = 2'd1,
        SHF_ROT   = 2'd2
    } shf_op_e;
endpackage

// File: rtl/shf_onehot_dec.sv
module shf_onehot_dec #(
    parameter int W = 32,
    parameter int CW = $clog2(W)
) (
    input  logic [CW-1:0] cnt,
    output logic [W-1:0]  onehot
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign onehot[i] = (cnt == CW'(i));
    end
endmodule

// File: rtl/shf_mul.sv
module shf_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0]   word,
    input  logic [W-1:0]   pow,
    input  logic           signed_word,
    output logic [2*W-1:0] prod
);
    logic [W:0]            a_ext;
    logic [W:0]            b_ext;
    logic signed [2*W+1:0] full;

    // Extend the word by one bit: sign copy when signed, zero otherwise.
    assign a_ext = {signed_word & word[W-1], word};
    assign b_ext = {1'b0, pow};
    assign full  = $signed(a_ext) * $signed(b_ext);
    assign prod  = full[2*W-1:0];
endmodule

// File: rtl/shf_pick.sv
module shf_pick
    import shf_pkg::*;
#(
    parameter int W = 32
) (
    input  shf_op_e        op,
    input  logic [2*W-1:0] prod,
    output logic [W-1:0]   res
);
    logic [W-1:0] lo_half;
    logic [W-1:0] hi_half;

    assign lo_half = prod[W-1:0];
    assign hi_half = prod[2*W-1:W];

    always_comb begin
        unique case (op)
            SHF_LEFT:  res = lo_half;
            SHF_RIGHT: res = hi_half;
            SHF_ROT:   res = hi_half | lo_half;
            default:   res = lo_half;
        endcase
    end
endmodule

// File: rtl/mulshift_rot.sv
module mulshift_rot
    import shf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         din,
    input  logic [W-1:0]         pow_in,
    input  logic [$clog2(W)-1:0] cnt_in,
    input  logic                 cnt_sel,
    input  logic                 dir_right,
    input  logic                 rot_en,
    input  logic                 sign_en,
    output logic [W-1:0]         dout
);
    localparam int CW = $clog2(W);

    shf_op_e        op;
    logic [W-1:0]   dec_pow;
    logic [W-1:0]   pow_sel;
    logic [2*W-1:0] prod;
    logic [W-1:0]   res_next;
    logic           signed_word;

    // Rotation has priority over the direction control.
    always_comb begin
        if (rot_en)         op = SHF_ROT;
        else if (dir_right) op = SHF_RIGHT;
        else                op = SHF_LEFT;
    end

    // Only the right shift can be arithmetic; rotation stays unsigned.
    assign signed_word = sign_en && (op == SHF_RIGHT);

    shf_onehot_dec #(.W(W), .CW(CW)) u_dec (
        .cnt    (cnt_in),
        .onehot (dec_pow)
    );

    assign pow_sel = cnt_sel ? dec_pow : pow_in;

    shf_mul #(.W(W)) u_mul (
        .word        (din),
        .pow         (pow_sel),
        .signed_word (signed_word),
        .prod        (prod)
    );

    shf_pick #(.W(W)) u_pick (
        .op   (op),
        .prod (prod),
        .res  (res_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout <= '0;
        else        dout <= res_next;
    end
endmodule

// File: rtl/mulshift_rot_chk.sv
module mulshift_rot_chk #(
    parameter int W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [W-1:0]         din,
    input logic [W-1:0]         pow_in,
    input logic [$clog2(W)-1:0] cnt_in,
    input logic                 cnt_sel,
    input logic                 dir_right,
    input logic                 rot_en,
    input logic                 sign_en,
    input logic [W-1:0]         dout
);
    // R3
    left_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_sel && !rot_en && !dir_right) |=> dout == $past(din << cnt_in));

    // R4
    lsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_sel && !rot_en && dir_right && !sign_en)
        |=> dout == $past(din >> (W - int'(cnt_in))));

    // R5
    asr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_sel && !rot_en && dir_right && sign_en)
        |=> dout == $past(W'($signed(din) >>> (W - int'(cnt_in)))));

    // R6 R7
    rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_sel && rot_en)
        |=> dout == $past((din << cnt_in) | (din >> (W - int'(cnt_in)))));

    // R8
    direct_pow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_sel && pow_in == W'(1) && !rot_en && !dir_right) |=> dout == $past(din));
endmodule

bind mulshift_rot mulshift_rot_chk #(.W(W)) u_chk (.*);

// File: tb/mulshift_rot_tb.sv
module mulshift_rot_tb;
    localparam int NV = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] din = '0;
    logic [31:0] pow_in = '0;
    logic [4:0]  cnt_in = '0;
    logic        cnt_sel = 1'b0;
    logic        dir_right = 1'b0;
    logic        rot_en = 1'b0;
    logic        sign_en = 1'b0;
    logic [31:0] dout;

    int errs = 0;
    int checks = 0;

    mulshift_rot u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .pow_in(pow_in), .cnt_in(cnt_in),
        .cnt_sel(cnt_sel), .dir_right(dir_right), .rot_en(rot_en),
        .sign_en(sign_en), .dout(dout)
    );

    always #5 clk = ~clk;

    // Vector columns: word, operand port, count, cnt_sel, dir_right, rot_en, sign_en, expected, requirement
    localparam logic [31:0] VD [NV] = '{
        32'hAABBCCDD, 32'hAABBCCDD, 32'hAABBCCDD, 32'hAABBCCDD, 32'hAABBCCDD,
        32'hAABBCCDD, 32'hAABBCCDD, 32'hAABBCCDD, 32'hAABBCCDD, 32'hAABBCCDD,
        32'h12345678, 32'h00000003, 32'h80000000, 32'h80000000, 32'hFFFFFFFF};
    localparam logic [31:0] VP [NV] = '{
        32'h100, 32'h100, 32'h100, 32'h100, 32'h100,
        32'h4, 32'h4, 32'h4, 32'h4, 32'h4,
        32'h0, 32'h0, 32'h0, 32'h0, 32'h80000000};
    localparam logic [4:0] VC [NV] = '{0, 0, 0, 0, 0, 8, 0, 0, 0, 0, 4, 31, 31, 31, 0};
    localparam logic VM [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0};
    localparam logic VR [NV] = '{0, 1, 1, 0, 1, 0, 0, 0, 1, 1, 1, 0, 1, 1, 0};
    localparam logic VT [NV] = '{0, 0, 0, 1, 1, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0};
    localparam logic VS [NV] = '{0, 0, 1, 0, 1, 0, 0, 1, 0, 1, 1, 0, 0, 1, 1};
    localparam logic [31:0] VE [NV] = '{
        32'hBBCCDD00,   // R10 left
        32'h000000AA,   // R10 logical right
        32'hFFFFFFAA,   // R10 arithmetic right
        32'hBBCCDDAA,   // R10 rotate
        32'hBBCCDDAA,   // R7 both controls high
        32'hBBCCDD00,   // R8 count path, operand port garbage
        32'hAABBCCDD,   // R3 count 0 left
        32'hAABBCCDD,   // R6 count 0 rotate, sign ignored
        32'h00000000,   // R4 count 0 logical right
        32'hFFFFFFFF,   // R5 count 0 arithmetic right
        32'h00000001,   // R5 positive word
        32'h80000001,   // R6 count 31 rotate
        32'h40000000,   // R4 count 31
        32'hC0000000,   // R5 count 31
        32'h80000000};  // R3 top operand bit, sign ignored
    localparam int VQ [NV] = '{10, 10, 10, 10, 7, 8, 3, 6, 4, 5, 5, 6, 4, 5, 3};

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [31:0] d, input logic [31:0] p, input logic [4:0] c,
                         input logic m, input logic r, input logic t, input logic s);
        din = d; pow_in = p; cnt_in = c; cnt_sel = m; dir_right = r; rot_en = t; sign_en = s;
    endtask

    function automatic logic [31:0] ref_res(input logic [31:0] d, input int n,
                                            input logic r, input logic t, input logic s);
        if (t)      return (d << n) | (d >> (32 - n));
        else if (r) return s ? 32'($signed(d) >>> (32 - n)) : (d >> (32 - n));
        else        return d << n;
    endfunction

    initial begin
        #2_000_000;
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        drive(32'hAABBCCDD, 32'h100, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        #12;
        check("R1 reset", dout, 32'h0);
        @(negedge clk);
        check("R1 reset held", dout, 32'h0);
        rst_n = 1'b1;

        // Table walked back to back (R9): drive at one negedge, check at the next.
        @(negedge clk);
        drive(VD[0], VP[0], VC[0], VM[0], VR[0], VT[0], VS[0]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check($sformatf("R%0d R9 vec%0d", VQ[i], i), dout, VE[i]);
            if (i + 1 < NV)
                drive(VD[i+1], VP[i+1], VC[i+1], VM[i+1], VR[i+1], VT[i+1], VS[i+1]);
        end

        // R2: output holds until the next rising edge
        drive(32'h0000FFFF, 32'h0, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0);
        #2;
        check("R2 hold before edge", dout, 32'h80000000);
        @(negedge clk);
        check("R2 after edge", dout, 32'h000FFFF0);

        // Sweep of all counts for every operation through the count path
        for (int n = 0; n < 32; n++) begin
            for (int k = 0; k < 4; k++) begin
                logic r, t, s;
                r = (k == 1 || k == 2);
                t = (k == 3);
                s = (k != 1);
                drive(32'h9ABCDEF1, 32'hFFFFFFFF, 5'(n), 1'b1, r, t, s);
                @(negedge clk);
                check($sformatf("R3 R4 R5 R6 sweep n=%0d k=%0d", n, k), dout,
                      ref_res(32'h9ABCDEF1, n, r, t, s));
            end
        end

        // R8: operand port path with the count set to a misleading value
        drive(32'h00000F0F, 32'h00000010, 5'd20, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R8 pow port", dout, 32'h0000F0F0);

        // R1: asynchronous reset in mid-operation
        #1 rst_n = 1'b0;
        #1;
        check("R1 async clear", dout, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule